// File: doc/BRIEF.md
# Locked Configuration Register Target on a Two-Wire Bus

This block is a two-wire serial bus target that holds the byte-wide configuration registers of a multiplexed monitor sequencer. A bus controller reaches it at one of four 7-bit addresses, picked by two address-select pins. Each transaction moves exactly one byte. A write frame carries the target address with R/W=0, a register pointer byte and one data byte. A read frame either names the target with R/W=1 directly, or first writes a pointer and then uses a repeated START. The block drives SDA only through an open-drain enable and never stretches SCL.

Registers fall into two groups. The sequence settings are the channel enables (0x04), the skip counts (0x05) and alternating polarity (0x06). They are kept as a live copy that the bus reads and writes, and a committed copy that feeds the sequencer. The committed copy is loaded on the falling edge of the active-low enable, or on a sequence-start pulse while the enable is low. The amplifier offset (0x07), common-mode code (0x08), timeout disable (0x0F), four bus gains (0x10-0x13), four shunt gains (0x20-0x23) and the lock register (0x24) drive their outputs as soon as they are written. The lock register has two sticky levels. One blocks data writes. The other makes the block deaf to the bus. Only reset clears them.

The bus engine is a single state machine with these states. IDLE waits for a START. ADDR shifts in the address byte. ACKA acknowledges a matching address. PTR shifts in the pointer and ACKP acknowledges it. WDAT shifts in the data byte and ACKW acknowledges it or declines it. RDAT shifts out the read byte and RACK lets the controller answer it. SKIP ignores the bus until the next condition. The transitions are these. A START from any state goes to ADDR, and a STOP from any state goes to IDLE. From ADDR, a complete byte goes to ACKA on a match and to SKIP otherwise. From ACKA, the SCL fall goes to RDAT for a read and to PTR for a write. PTR goes to ACKP, ACKP to WDAT and WDAT to ACKW, each on a complete byte or on the SCL fall. From ACKW the next fall goes to SKIP. RDAT goes to RACK after eight bits, and RACK goes to SKIP on the next fall.

Top module: `cfgi2c_target`

## Requirements
- R1: The target answers only the 7-bit address formed as 0x34 plus the two address-select bits (0x34 to 0x37). It does not acknowledge any other address and does not drive SDA for the rest of that transaction.
- R2: In a write frame (address with R/W=0, pointer byte, data byte, MSB first) the block acknowledges all three bytes by pulling SDA low in each ninth clock and stores the data byte at the pointed register.
- R3: A pointer write followed by a repeated START and the address with R/W=1 returns the pointed register MSB first. The block releases SDA after the eighth data bit, whether the controller answers with ACK or NACK.
- R4: After reset, register 0x00 reads 0x4F, 0x01 reads 0x2D, 0x04 reads 0x0F, 0x08 reads 0x07, and every other register reads 0x00. The outputs carry the same values.
- R5: Only defined fields are stored; undefined bits read 0. 0x04 keeps bits 7 and 5:0. 0x05 keeps all bits. 0x06 and 0x0F keep bit 7. 0x07 keeps bits 1:0. 0x08 keeps bits 3:0. The gain registers keep bits 5:1, which form a 5-bit gain code.
- R6: Writes and reads to an unmapped address are acknowledged. An unmapped read returns 0x00 and an unmapped write changes nothing. Writes to 0x00 and 0x01 are acknowledged and ignored.
- R7: The offset, common-mode, timeout-disable and gain outputs change only as a result of a completed write to their register, and they take the new value right after that write.
- R8: While the enable input is high, the sequence outputs hold their committed values even when 0x04-0x06 are written. On the falling edge of the enable they take the live register values.
- R9: While the enable is low, writes to 0x04-0x06 reach the sequence outputs only on a sequence-start pulse. A sequence-start pulse while the enable is high has no effect.
- R10: Writing bit 1 of 0x24 sets a write lock. From then on, data bytes are not acknowledged and not stored, while reads are still served. The lock survives later writes and clears only on reset.
- R11: Writing bit 0 of 0x24 sets a full lock. From then on, the block acknowledges nothing and never drives SDA, including for its own address, until reset.
- R12: A STOP or START that arrives in the middle of a byte ends the transaction and leaves every register unchanged.
- R13: SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low reset; clears the locks and restores the defaults |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| adr_sel | input | 2 | Low two bits of the target address |
| en_n | input | 1 | Active-low sequencer enable; its falling edge commits the sequence settings |
| seq_start | input | 1 | One-cycle pulse at the start of each sequencer cycle |
| seq_chan | output | 8 | Committed channel enables (0x04) |
| seq_skip | output | 8 | Committed skip counts (0x05) |
| seq_alt | output | 1 | Committed alternating polarity (0x06 bit 7) |
| amp_offset | output | 2 | Offset code (0x07) |
| amp_cm | output | 4 | Common-mode code (0x08) |
| tmo_off | output | 1 | Timeout disable (0x0F bit 7) |
| bus_gain | output | 20 | Four 5-bit bus gain codes, channel 0 in the low bits |
| shunt_gain | output | 20 | Four 5-bit shunt gain codes, channel 0 in the low bits |
| lock_wr | output | 1 | Write lock level is set |
| lock_all | output | 1 | Full lock level is set |

## Verification
The bench goes after the pointer-then-repeated-START read. In that read the controller's SDA rise before the repeated START clocks a stray bit, so a design that did not clear its bit counter on START would misread the address. It also writes 0x04-0x06 with the enable high and then with it low, and pulses sequence-start in both cases. A design that committed on every write, or ignored the enable level, would move the sequencer outputs too early. It ends bytes with a STOP or START after four or three bits, and a design that stored partial bytes would corrupt 0x07 or 0x08. The last part sets each lock level in turn. A design whose lock was not sticky would accept the write after the write lock, and one that still matched its address under the full lock would pull SDA low where the bench expects 0xFF.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] ADDR_HI = 5'b01101;  // upper bits of 0x34

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACKA,
        ST_PTR,
        ST_ACKP,
        ST_WDAT,
        ST_ACKW,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } link_state_t;
endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign ev_rise  = scl_s & ~scl_p;
    assign ev_fall  = ~scl_s & scl_p;
    assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
    assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfgi2c_link.sv
module cfgi2c_link
    import cfgi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic [6:0]        dev_addr,
    input  logic              lock_wr,
    input  logic              lock_all,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    link_state_t state, nxt;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh, tx, ptr;
    logic              rw;

    wire byte_done = ev_fall && (cnt == 4'd8);
    wire addr_hit  = (sh[7:1] == dev_addr) && !lock_all;

    assign wr_addr = ptr;
    assign rd_addr = ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (ev_start)     nxt = ST_ADDR;
        else if (ev_stop) nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE, ST_SKIP: nxt = state;
                ST_ADDR: if (byte_done) nxt = addr_hit ? ST_ACKA : ST_SKIP;
                ST_ACKA: if (ev_fall)   nxt = rw ? ST_RDAT : ST_PTR;
                ST_PTR:  if (byte_done) nxt = ST_ACKP;
                ST_ACKP: if (ev_fall)   nxt = ST_WDAT;
                ST_WDAT: if (byte_done) nxt = ST_ACKW;
                ST_ACKW: if (ev_fall)   nxt = ST_SKIP;
                ST_RDAT: if (ev_fall && cnt == 4'd7) nxt = ST_RACK;
                ST_RACK: if (ev_fall)   nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev_start || ev_stop) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDAT: begin
                        if (ev_rise && cnt != 4'd8) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                rw     <= sh[0];
                                sda_oe <= addr_hit;
                            end else if (state == ST_PTR) begin
                                ptr    <= sh;
                                sda_oe <= 1'b1;
                            end else begin
                                wr_data <= sh;
                                wr_en   <= !lock_wr;
                                sda_oe  <= !lock_wr;
                            end
                        end
                    end
                    ST_ACKA: if (ev_fall) begin
                        cnt    <= '0;
                        tx     <= rd_data;
                        sda_oe <= rw && !rd_data[7];
                    end
                    ST_ACKP, ST_ACKW, ST_RACK: if (ev_fall) sda_oe <= 1'b0;
                    ST_RDAT: if (ev_fall) begin
                        if (cnt == 4'd7) sda_oe <= 1'b0;
                        else begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= !tx[6];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R13: the data line enable never moves during an SCL high phase
    a_r13_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R11: an address acknowledge never happens under the full lock
    a_r11_deaf_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACKA) |-> !lock_all);
endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs
    import cfgi2c_pkg::*;
#(
    parameter int              NG        = 4,
    parameter int              GW        = 5,
    parameter logic [7:0]      VENDOR_ID = 8'h4F,
    parameter logic [7:0]      DEVICE_ID = 8'h2D,
    parameter logic [7:0]      BUS_BASE  = 8'h10,
    parameter logic [7:0]      SHT_BASE  = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              en_n,
    input  logic              seq_start,
    output logic [7:0]        seq_chan,
    output logic [7:0]        seq_skip,
    output logic              seq_alt,
    output logic [1:0]        amp_offset,
    output logic [3:0]        amp_cm,
    output logic              tmo_off,
    output logic [NG*GW-1:0]  bus_gain,
    output logic [NG*GW-1:0]  shunt_gain,
    output logic              lock_wr,
    output logic              lock_all
);
    logic [7:0]    chan_q, skip_q;
    logic          alt_q, tmo_q, en_q;
    logic [1:0]    off_q, lock_q;
    logic [3:0]    cm_q;
    logic [GW-1:0] bg_q [NG];
    logic [GW-1:0] sg_q [NG];

    wire commit = (en_q && !en_n) || (!en_n && seq_start);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= 8'h0F;
            skip_q <= '0;
            alt_q  <= 1'b0;
            off_q  <= '0;
            cm_q   <= 4'h7;
            tmo_q  <= 1'b0;
            lock_q <= '0;
            for (int i = 0; i < NG; i++) begin
                bg_q[i] <= '0;
                sg_q[i] <= '0;
            end
        end else if (wr_en) begin
            unique case (wr_addr)
                8'h04:   chan_q <= wr_data & 8'hBF;
                8'h05:   skip_q <= wr_data;
                8'h06:   alt_q  <= wr_data[7];
                8'h07:   off_q  <= wr_data[1:0];
                8'h08:   cm_q   <= wr_data[3:0];
                8'h0F:   tmo_q  <= wr_data[7];
                8'h24:   lock_q <= lock_q | wr_data[1:0];
                default: ;
            endcase
            for (int i = 0; i < NG; i++) begin
                if (wr_addr == BUS_BASE + 8'(i)) bg_q[i] <= wr_data[GW:1];
                if (wr_addr == SHT_BASE + 8'(i)) sg_q[i] <= wr_data[GW:1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b1;
            seq_chan <= 8'h0F;
            seq_skip <= '0;
            seq_alt  <= 1'b0;
        end else begin
            en_q <= en_n;
            if (commit) begin
                seq_chan <= chan_q;
                seq_skip <= skip_q;
                seq_alt  <= alt_q;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            8'h00:   rd_data = VENDOR_ID;
            8'h01:   rd_data = DEVICE_ID;
            8'h04:   rd_data = chan_q;
            8'h05:   rd_data = skip_q;
            8'h06:   rd_data = {alt_q, 7'b0};
            8'h07:   rd_data = {6'b0, off_q};
            8'h08:   rd_data = {4'b0, cm_q};
            8'h0F:   rd_data = {tmo_q, 7'b0};
            8'h24:   rd_data = {6'b0, lock_q};
            default: ;
        endcase
        for (int i = 0; i < NG; i++) begin
            if (rd_addr == BUS_BASE + 8'(i)) rd_data = {{(7-GW){1'b0}}, bg_q[i], 1'b0};
            if (rd_addr == SHT_BASE + 8'(i)) rd_data = {{(7-GW){1'b0}}, sg_q[i], 1'b0};
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_gain_out
        assign bus_gain[g*GW +: GW]   = bg_q[g];
        assign shunt_gain[g*GW +: GW] = sg_q[g];
    end

    assign amp_offset = off_q;
    assign amp_cm     = cm_q;
    assign tmo_off    = tmo_q;
    assign lock_wr    = lock_q[1];
    assign lock_all   = lock_q[0];

    // R10 / R11: lock levels never drop once set
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q[1]) |-> lock_q[1]);
    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q[0]) |-> lock_q[0]);
    // R7: immediate settings move only after a write strobe from the bus engine
    a_r7_imm_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(off_q) && $stable(cm_q) && $stable(tmo_q)));
    // R8: sequencer view frozen while disabled
    a_r8_hold_while_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_n) |-> ($stable(seq_chan) && $stable(seq_skip) && $stable(seq_alt)));
endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target
    import cfgi2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_GAIN    = 4,
    parameter int GAIN_W      = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [1:0]                 adr_sel,
    input  logic                       en_n,
    input  logic                       seq_start,
    output logic [7:0]                 seq_chan,
    output logic [7:0]                 seq_skip,
    output logic                       seq_alt,
    output logic [1:0]                 amp_offset,
    output logic [3:0]                 amp_cm,
    output logic                       tmo_off,
    output logic [NUM_GAIN*GAIN_W-1:0] bus_gain,
    output logic [NUM_GAIN*GAIN_W-1:0] shunt_gain,
    output logic                       lock_wr,
    output logic                       lock_all
);
    logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop, wr_en;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

    cfgi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
        .ev_start(ev_start), .ev_stop(ev_stop)
    );

    cfgi2c_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
        .dev_addr({ADDR_HI, adr_sel}), .lock_wr(lock_wr), .lock_all(lock_all),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cfgi2c_regs #(.NG(NUM_GAIN), .GW(GAIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .en_n(en_n), .seq_start(seq_start),
        .seq_chan(seq_chan), .seq_skip(seq_skip), .seq_alt(seq_alt),
        .amp_offset(amp_offset), .amp_cm(amp_cm), .tmo_off(tmo_off),
        .bus_gain(bus_gain), .shunt_gain(shunt_gain),
        .lock_wr(lock_wr), .lock_all(lock_all)
    );
endmodule

// File: tb/sim_cfgi2c_target.sv
module sim_cfgi2c_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] adr_sel = 2'b00;
    logic en_n = 1'b1, seq_start = 1'b0;
    logic sda_oe, seq_alt, tmo_off, lock_wr, lock_all;
    logic [7:0] seq_chan, seq_skip;
    logic [1:0] amp_offset;
    logic [3:0] amp_cm;
    logic [19:0] bus_gain, shunt_gain;
    wire sda_w = sda_m & ~sda_oe;

    int checks = 0, fails = 0, viol = 0;
    bit done = 0;
    logic [7:0] mdl [0:255];
    logic [7:0] c_chan, c_skip;
    logic c_alt;

    always #4 clk = ~clk;

    cfgi2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe(sda_oe),
        .adr_sel(adr_sel), .en_n(en_n), .seq_start(seq_start),
        .seq_chan(seq_chan), .seq_skip(seq_skip), .seq_alt(seq_alt),
        .amp_offset(amp_offset), .amp_cm(amp_cm), .tmo_off(tmo_off),
        .bus_gain(bus_gain), .shunt_gain(shunt_gain),
        .lock_wr(lock_wr), .lock_all(lock_all)
    );

    // R13 monitor: enable must not move while SCL stays high
    logic scl_prev = 1'b1, oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe != oe_prev)) viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_w; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(x);
        ack = (x == 1'b0);
    endtask

    task automatic get_byte(output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin recv_bit(x); b[i] = x; end
        send_bit(1'b1);
    endtask

    task automatic wr_reg(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d,
                          output logic [2:0] acks);
        logic k;
        i2c_start;
        put_byte({dev, 1'b0}, k); acks[2] = k;
        put_byte(a, k);           acks[1] = k;
        put_byte(d, k);           acks[0] = k;
        i2c_stop;
    endtask

    task automatic rd_reg(input logic [6:0] dev, input logic [7:0] a, output logic [7:0] d,
                          output logic [2:0] acks);
        logic k;
        i2c_start;
        put_byte({dev, 1'b0}, k); acks[2] = k;
        put_byte(a, k);           acks[1] = k;
        i2c_start;
        put_byte({dev, 1'b1}, k); acks[0] = k;
        get_byte(d);
        i2c_stop;
    endtask

    function automatic logic [7:0] store(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h04: return d & 8'hBF;
            8'h05: return d;
            8'h06, 8'h0F: return d & 8'h80;
            8'h07: return d & 8'h03;
            8'h08: return d & 8'h0F;
            8'h10, 8'h11, 8'h12, 8'h13, 8'h20, 8'h21, 8'h22, 8'h23: return d & 8'h3E;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit writable(input logic [7:0] a);
        return (a >= 8'h04 && a <= 8'h08) || a == 8'h0F ||
               (a >= 8'h10 && a <= 8'h13) || (a >= 8'h20 && a <= 8'h23);
    endfunction

    function automatic logic [7:0] pick(input int n);
        case (n)
            0: return 8'h04;  1: return 8'h05;  2: return 8'h06;  3: return 8'h07;
            4: return 8'h08;  5: return 8'h0F;  6: return 8'h10;  7: return 8'h11;
            8: return 8'h12;  9: return 8'h13; 10: return 8'h20; 11: return 8'h21;
            12: return 8'h22; 13: return 8'h23; 14: return 8'h00; 15: return 8'h01;
            16: return 8'h09; default: return 8'h3C;
        endcase
    endfunction

    task automatic mdl_reset;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        mdl[8'h00] = 8'h4F; mdl[8'h01] = 8'h2D; mdl[8'h04] = 8'h0F; mdl[8'h08] = 8'h07;
        c_chan = 8'h0F; c_skip = 8'h00; c_alt = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
        mdl_reset;
    endtask

    task automatic write_m(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
        wr_reg(7'h34, a, d, acks);
        if (writable(a)) mdl[a] = store(a, d);
    endtask

    task automatic chk_imm(input string req);
        check(req, {30'b0, amp_offset}, {30'b0, mdl[8'h07][1:0]});
        check(req, {28'b0, amp_cm}, {28'b0, mdl[8'h08][3:0]});
        check(req, {31'b0, tmo_off}, {31'b0, mdl[8'h0F][7]});
        check(req, {12'b0, bus_gain}, {12'b0, mdl[8'h13][5:1], mdl[8'h12][5:1],
                                       mdl[8'h11][5:1], mdl[8'h10][5:1]});
        check(req, {12'b0, shunt_gain}, {12'b0, mdl[8'h23][5:1], mdl[8'h22][5:1],
                                         mdl[8'h21][5:1], mdl[8'h20][5:1]});
    endtask

    task automatic chk_seq(input string req);
        check(req, {24'b0, seq_chan}, {24'b0, c_chan});
        check(req, {24'b0, seq_skip}, {24'b0, c_skip});
        check(req, {31'b0, seq_alt}, {31'b0, c_alt});
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete");
            summary;
            $finish;
        end
    end

    initial begin
        logic [2:0] ak;
        logic [7:0] d;
        logic k;
        void'($urandom(32'h5EED_0042));
        mdl_reset;
        tick(4); rst_n = 1'b1; tick(4);

        // R4: reset state at the ports
        check("R4 sda_oe", {31'b0, sda_oe}, 0);
        chk_seq("R4 seq");
        chk_imm("R4 imm");
        check("R4 locks", {30'b0, lock_wr, lock_all}, 0);

        // R4 / R3: default contents via pointer write and repeated start
        foreach (mdl[i]) if (i == 0 || i == 1 || i == 4 || i == 8 || i == 5 || i == 8'h24) begin
            rd_reg(7'h34, 8'(i), d, ak);
            check("R3 acks", {29'b0, ak}, 3'b111);
            check("R4 default", {24'b0, d}, {24'b0, mdl[i]});
        end

        // R1: foreign address ignored
        wr_reg(7'h30, 8'h07, 8'h03, ak);
        check("R1 foreign nack", {29'b0, ak}, 3'b000);
        check("R1 no write", {30'b0, amp_offset}, 0);
        // R1: address select moves the address
        adr_sel = 2'b10;
        wr_reg(7'h36, 8'h08, 8'h0A, ak);
        check("R1 sel 0x36 ack", {29'b0, ak}, 3'b111);
        wr_reg(7'h34, 8'h08, 8'h05, ak);
        check("R1 old addr nack", {29'b0, ak}, 3'b000);
        check("R1 cm from 0x36", {28'b0, amp_cm}, 4'hA);
        adr_sel = 2'b00;
        mdl[8'h08] = 8'h0A;

        // R2 / R5 / R7: write, field masking, immediate output
        write_m(8'h07, 8'hFF, ak);
        check("R2 acks", {29'b0, ak}, 3'b111);
        check("R7 offset now", {30'b0, amp_offset}, 2'b11);
        rd_reg(7'h34, 8'h07, d, ak);
        check("R5 offset mask", {24'b0, d}, 8'h03);
        write_m(8'h12, 8'hFF, ak);
        rd_reg(7'h34, 8'h12, d, ak);
        check("R5 gain mask", {24'b0, d}, 8'h3E);
        check("R7 gain out", {27'b0, bus_gain[14:10]}, 5'd31);

        // R6: unmapped and ID registers
        wr_reg(7'h34, 8'h40, 8'hA5, ak);
        check("R6 unmapped acks", {29'b0, ak}, 3'b111);
        rd_reg(7'h34, 8'h40, d, ak);
        check("R6 unmapped acks rd", {29'b0, ak}, 3'b111);
        check("R6 unmapped read", {24'b0, d}, 8'h00);
        wr_reg(7'h34, 8'h00, 8'h12, ak);
        rd_reg(7'h34, 8'h00, d, ak);
        check("R6 id kept", {24'b0, d}, 8'h4F);
        chk_imm("R6 no side effect");

        // R8 / R9: commit while disabled, then on enable fall
        write_m(8'h04, 8'hC9, ak);
        write_m(8'h06, 8'hFF, ak);
        tick(3);
        chk_seq("R8 held while en_n high");
        seq_start = 1'b1; tick(1); seq_start = 1'b0; tick(3);
        chk_seq("R9 pulse ignored while en_n high");
        rd_reg(7'h34, 8'h04, d, ak);
        check("R5 chan mask", {24'b0, d}, 8'h89);
        en_n = 1'b0; tick(3);
        c_chan = mdl[8'h04]; c_skip = mdl[8'h05]; c_alt = mdl[8'h06][7];
        chk_seq("R8 commit on enable fall");
        write_m(8'h05, 8'h3C, ak);
        tick(3);
        chk_seq("R9 held until seq start");
        seq_start = 1'b1; tick(1); seq_start = 1'b0; tick(2);
        c_skip = 8'h3C;
        chk_seq("R9 commit on seq start");

        // R12: stop and start in the middle of a data byte
        i2c_start; put_byte(8'h68, k); put_byte(8'h07, k);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i2c_stop;
        rd_reg(7'h34, 8'h07, d, ak);
        check("R12 stop abort", {24'b0, d}, {24'b0, mdl[8'h07]});
        i2c_start; put_byte(8'h68, k); put_byte(8'h08, k);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        i2c_start; i2c_stop;
        rd_reg(7'h34, 8'h08, d, ak);
        check("R12 start abort", {24'b0, d}, {24'b0, mdl[8'h08]});

        // R2 / R5 / R6 / R7: random writes and reads
        for (int n = 0; n < 26; n++) begin
            logic [7:0] a, ra, dv;
            a  = pick($urandom_range(0, 17));
            dv = 8'($urandom);
            write_m(a, dv, ak);
            check("R2 random acks", {29'b0, ak}, 3'b111);
            ra = pick($urandom_range(0, 17));
            rd_reg(7'h34, ra, d, ak);
            check("R5 random read", {24'b0, d}, {24'b0, mdl[ra]});
            chk_imm("R7 random imm");
        end
        seq_start = 1'b1; tick(1); seq_start = 1'b0; tick(2);
        c_chan = mdl[8'h04]; c_skip = mdl[8'h05]; c_alt = mdl[8'h06][7];
        chk_seq("R9 random commit");

        // R10: write lock
        wr_reg(7'h34, 8'h24, 8'h02, ak);
        check("R10 lock write acked", {29'b0, ak}, 3'b111);
        check("R10 lock_wr set", {31'b0, lock_wr}, 1);
        wr_reg(7'h34, 8'h07, ~mdl[8'h07], ak);
        check("R10 data nacked", {29'b0, ak}, 3'b110);
        rd_reg(7'h34, 8'h07, d, ak);
        check("R10 reads served", {29'b0, ak}, 3'b111);
        check("R10 value kept", {24'b0, d}, {24'b0, mdl[8'h07]});
        wr_reg(7'h34, 8'h24, 8'h01, ak);
        check("R10 sticky, no full lock", {30'b0, lock_wr, lock_all}, 2'b10);

        // R11: full lock after reset
        do_reset;
        check("R10 reset clears", {30'b0, lock_wr, lock_all}, 0);
        wr_reg(7'h34, 8'h24, 8'h01, ak);
        check("R11 lock_all set", {31'b0, lock_all}, 1);
        rd_reg(7'h34, 8'h00, d, ak);
        check("R11 deaf acks", {29'b0, ak}, 3'b000);
        check("R11 deaf data", {24'b0, d}, 8'hFF);
        wr_reg(7'h34, 8'h08, 8'h0C, ak);
        check("R11 write ignored", {28'b0, amp_cm}, 4'h7);
        do_reset;
        rd_reg(7'h34, 8'h01, d, ak);
        check("R11 reset restores", {21'b0, ak, d}, {21'b0, 3'b111, 8'h2D});

        check("R13 sda stable during scl high", viol, 0);
        done = 1;
        summary;
        $finish;
    end
endmodule